// File: doc/BRIEF.md
# Bit-Masked General-Purpose I/O Port

This block is an eight-pin general-purpose I/O port that sits on a small memory-mapped register bus, one byte wide. Each pin has a direction bit and an output data bit. The pin's pad input passes through a two-flop synchroniser before the bus can see it. Software sets the direction of each pin by writing one direction register.

Software reaches pin values through a data window. In that window the address itself carries an eight-bit lane mask, so one bus access can touch any subset of pins with no read-modify-write. A write changes only the masked pins, and of those only the pins that are outputs at the moment of the write. Masked output bits are written; masked input bits are dropped. A read returns the pin state for masked lanes and zero for all other lanes.

The bus has no handshake. Every access completes in the cycle it is presented. A write is applied at the clock edge where `bus_wr` is high. Read data is combinational from the current address and register state. The block therefore never applies back-pressure, and there is no valid/ready pair.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, all pins are inputs and the output data is zero: `pad_oe` reads 0x00, `pad_out` reads 0x00, and the direction register reads back 0x00.
- R2: The direction register sits at byte offset 0x400. A write there loads `pad_oe` with the write data at the next clock edge, where bit value 1 means output. A read at 0x400 returns the stored direction.
- R3: An address below 0x400 selects the data window, with lane mask bit i equal to address bit i+2. A write there changes output bit i only when mask bit i is 1. Every other output bit keeps its value.
- R4: A data write to a pin that is an input when the write occurs is discarded. If that pin later becomes an output, it drives the value it held before the discarded write, until software writes it again.
- R5: A read in the data window returns 0 in every lane whose mask bit is 0.
- R6: In a masked lane, a data read returns the driven output bit if the pin is an output. It returns the synchronised pad value if the pin is an input.
- R7: A change on `pad_in` becomes visible to data reads after exactly two rising clock edges. After one edge, reads still return the old value.
- R8: Any address of 0x400 or above other than 0x400 itself reads as 0x00. A write to such an address changes neither the direction nor the output data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe; a write is applied at the next rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_oe | output | 8 | Per-pin output enable (1 = drive) |
| pad_out | output | 8 | Per-pin output value |

## Verification
The assertions assume that `bus_addr`, `bus_wr` and `bus_wdata` are stable around each rising edge and never unknown while reset is released. They also assume that `pad_in` is a defined level at every clock edge, even though its changes are asynchronous. The bench drives all bus and pad inputs only on falling edges and holds them for a full cycle. It uses only defined values, so every edge sees settled inputs. The synchroniser check starts only after two clocks out of reset, so that no pre-reset pad value enters the comparison.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int unsigned PIN_COUNT  = 8;
  localparam int unsigned BUS_AW     = 12;
  localparam int unsigned MASK_SHIFT = 2;
  localparam logic [BUS_AW-1:0] DIR_OFFSET = 12'h400;

  typedef logic [PIN_COUNT-1:0] pin_vec_t;
  typedef logic [BUS_AW-1:0]    bus_addr_t;

  typedef enum logic [1:0] {
    SPACE_DATA = 2'd0,
    SPACE_DIR  = 2'd1,
    SPACE_NONE = 2'd2
  } space_e;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stable_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_in;
      stable_q <= meta_q;
    end
  end

  assign sync_out = stable_q;

  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (!rst_n)          warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  assert_two_edge_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 2'd2) |-> (sync_out == $past(async_in, 2)));
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_mask_pkg::*;
(
  input  bus_addr_t addr,
  output space_e    space,
  output pin_vec_t  lane_mask
);
  always_comb begin
    if (addr < DIR_OFFSET)       space = SPACE_DATA;
    else if (addr == DIR_OFFSET) space = SPACE_DIR;
    else                         space = SPACE_NONE;
  end

  for (genvar g = 0; g < PIN_COUNT; g++) begin : g_lane
    assign lane_mask[g] = (space == SPACE_DATA) && addr[g + MASK_SHIFT];
  end
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
  import gpio_mask_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  space_e   space,
  input  pin_vec_t lane_mask,
  input  pin_vec_t wdata,
  output pin_vec_t dir_q,
  output pin_vec_t out_q
);
  pin_vec_t write_lanes;
  assign write_lanes = lane_mask & dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (wr && space == SPACE_DIR) begin
      dir_q <= wdata;
    end
  end

  for (genvar g = 0; g < PIN_COUNT; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        out_q[g] <= 1'b0;
      else if (wr && space == SPACE_DATA && write_lanes[g])
        out_q[g] <= wdata[g];
    end
  end

  assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && space == SPACE_DIR) |=> (dir_q == $past(wdata)));

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && space == SPACE_DATA) |=> $stable(out_q));

  assert_unmapped_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && space == SPACE_NONE) |=> ($stable(dir_q) && $stable(out_q)));
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] bus_addr,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [7:0]  pad_in,
  output logic [7:0]  pad_oe,
  output logic [7:0]  pad_out
);
  space_e   space;
  pin_vec_t lane_mask;
  pin_vec_t dir_q;
  pin_vec_t out_q;
  pin_vec_t pad_sync;
  pin_vec_t pin_view;

  gpio_addr_decode u_decode (
    .addr      (bus_addr),
    .space     (space),
    .lane_mask (lane_mask)
  );

  gpio_pin_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (bus_wr),
    .space     (space),
    .lane_mask (lane_mask),
    .wdata     (bus_wdata),
    .dir_q     (dir_q),
    .out_q     (out_q)
  );

  gpio_pad_sync #(.WIDTH(PIN_COUNT)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pad_sync)
  );

  assign pin_view = (out_q & dir_q) | (pad_sync & ~dir_q);

  always_comb begin
    unique case (space)
      SPACE_DATA: bus_rdata = pin_view & lane_mask;
      SPACE_DIR:  bus_rdata = dir_q;
      default:    bus_rdata = '0;
    endcase
  end

  assign pad_oe  = dir_q;
  assign pad_out = out_q;

  assert_input_write_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> (((pad_out ^ $past(pad_out)) & ~$past(pad_oe)) == 8'h00));

  assert_masked_lanes_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr < 12'h400) |-> ((bus_rdata & ~lane_mask) == 8'h00));

  assert_unmapped_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > 12'h400) |-> (bus_rdata == 8'h00));
endmodule

// File: tb/test_gpio_mask_port.sv
module test_gpio_mask_port;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  // vector: {wr, addr[11:0], wdata[7:0], exp_rd[7:0], exp_oe[7:0], exp_out[7:0]}
  localparam logic [44:0] VEC [NVEC] = '{
    {1'b1, 12'h400, 8'h0F, 8'h0F, 8'h0F, 8'h00},  // R2 dir write
    {1'b1, 12'h3FC, 8'hAA, 8'h3A, 8'h0F, 8'h0A},  // R3 R6 full mask
    {1'b1, 12'h00C, 8'hFF, 8'h03, 8'h0F, 8'h0B},  // R3 lanes 0,1
    {1'b0, 12'h3C0, 8'h00, 8'h30, 8'h0F, 8'h0B},  // R5 R6 input lanes
    {1'b1, 12'h3C0, 8'hFF, 8'h30, 8'h0F, 8'h0B},  // R4 write to inputs
    {1'b1, 12'h400, 8'hFF, 8'hFF, 8'hFF, 8'h0B},  // R4 switch to outputs
    {1'b0, 12'h3FC, 8'h00, 8'h0B, 8'hFF, 8'h0B},  // R4 R6 old values driven
    {1'b1, 12'h200, 8'h80, 8'h80, 8'hFF, 8'h8B},  // R3 lane 7
    {1'b1, 12'h090, 8'h00, 8'h00, 8'hFF, 8'h8B},  // R3 lanes 2,5
    {1'b1, 12'h404, 8'h00, 8'h00, 8'hFF, 8'h8B},  // R8 unmapped
    {1'b1, 12'h400, 8'h00, 8'h00, 8'h00, 8'h8B},  // R2 all inputs
    {1'b0, 12'h3FC, 8'h00, 8'h3C, 8'h00, 8'h8B},  // R6 pad view
    {1'b0, 12'h000, 8'h00, 8'h00, 8'h00, 8'h8B}   // R5 empty mask
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [7:0]  pad_in;
  logic [7:0]  pad_oe;
  logic [7:0]  pad_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mask_port i_gpio_mask_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [11:0] a, input logic [7:0] d);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; pad_in = 8'h3C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check8("R1 pad_oe", pad_oe, 8'h00);
    check8("R1 pad_out", pad_out, 8'h00);
    bus_addr = 12'h400;
    #1 check8("R1 dir readback", bus_rdata, 8'h00);
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][44], VEC[i][43:32], VEC[i][31:24]);
      check8($sformatf("vec%0d R2/R3/R4/R5/R6/R8 rdata", i), bus_rdata, VEC[i][23:16]);
      check8($sformatf("vec%0d R2 pad_oe", i), pad_oe, VEC[i][15:8]);
      check8($sformatf("vec%0d R3/R4 pad_out", i), pad_out, VEC[i][7:0]);
    end

    // R8: high address space write ignored
    step(1'b1, 12'h800, 8'hFF);
    check8("R8 read at 0x800", bus_rdata, 8'h00);
    check8("R8 pad_out kept", pad_out, 8'h8B);
    check8("R8 pad_oe kept", pad_oe, 8'h00);

    // R7: two-edge synchroniser latency, all pins inputs
    bus_addr = 12'h3FC;
    pad_in = 8'hC5;
    @(posedge clk); @(negedge clk);
    check8("R7 after one edge", bus_rdata, 8'h3C);
    @(posedge clk); @(negedge clk);
    check8("R7 after two edges", bus_rdata, 8'hC5);

    // R1: reset again from a non-zero state
    step(1'b1, 12'h400, 8'hF0);
    check8("R2 dir set before reset", pad_oe, 8'hF0);
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    check8("R1 pad_oe after reset", pad_oe, 8'h00);
    check8("R1 pad_out after reset", pad_out, 8'h00);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule